// File: doc/BRIEF.md
# Three-Source Raster Operation Pixel Unit

This block is a pipelined per-pixel combiner for a 2D rendering engine. Each accepted beat carries three source pixels and the current destination pixel. Every input is widened to 32-bit ARGB according to its own depth setting. The three sources are then merged bit by bit under an 8-bit raster operation code. A plane mask decides which destination bits may take the new value. A chroma-key test on the destination can cancel the write. The result is narrowed to the destination depth and handed to the writeback path together with a write-enable flag.

Pixels move over a valid/ready stream that accepts one beat per cycle. The configuration inputs are static: they must not change while any pixel is inside the pipeline. Memory fetch, addressing and pattern expansion belong to neighbouring blocks.

Top module: `rop3_pixel_unit`

## Requirements
- R1: A 16-bit input holds RGB565 in bits [15:0] (red [15:11], green [10:5], blue [4:0]), and its bits [31:16] are ignored. It is widened to ARGB8888 (alpha [31:24], red [23:16], green [15:8], blue [7:0]). Alpha becomes 8'hFF. Each channel keeps its bits in the high positions, and its top bits are repeated to fill the low positions.
- R2: Each source and the destination has its own depth select (1 = 16-bit, 0 = 32-bit). A 32-bit input is used unchanged, whatever depth the other inputs have.
- R3: For every bit position b, result bit b equals code bit {src2[b], src1[b], src0[b]}, taken as a 3-bit index with src2 as the MSB. Here src0 is src_i[31:0], src1 is src_i[63:32] and src2 is src_i[95:64], each taken after widening.
- R4: A plane-mask bit of 1 lets that bit of the widened destination take the raster result. A mask bit of 0 keeps the destination bit.
- R5: When keying is enabled and the widened destination equals the 32-bit key color, out_we_o is 0 and the output pixel is the destination unchanged. In every other case out_we_o is 1.
- R6: With a 16-bit destination, the output is {16'h0, R[23:19], G[15:10], B[7:3]} of the 32-bit result. Alpha and the low bits of each channel are dropped.
- R7: When the output is not stalled, a beat accepted in cycle n appears on the output in cycle n+3. The unit accepts one beat per cycle, and in_ready_o is high whenever the output holds no valid beat.
- R8: While out_valid_o is high and out_ready_i is low, the output pixel and the write flag hold. No beat is lost, duplicated or reordered.
- R9: During and right after reset, out_valid_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Unit can take a beat |
| src_i | input | 96 | Three source pixels, src0 in the low word |
| dst_i | input | 32 | Destination pixel read back |
| rop_code_i | input | 8 | Ternary raster operation code |
| src_is16_i | input | 3 | Per-source depth select, 1 = RGB565 |
| dst_is16_i | input | 1 | Destination depth select, 1 = RGB565 |
| key_en_i | input | 1 | Destination chroma-key enable |
| key_color_i | input | 32 | Key color in widened 32-bit form |
| plane_mask_i | input | 32 | Bits of the destination allowed to change |
| out_valid_o | output | 1 | Result beat valid |
| out_ready_i | input | 1 | Writeback can take the beat |
| out_pix_o | output | 32 | Result pixel at destination depth |
| out_we_o | output | 1 | Write enable, 0 when keyed out |

## Verification
The bench uses the codes that copy one source (AA, CC, F0), together with XOR and AND of all three and the constant codes. A wrong index order would send the wrong source through, and a swapped bit would break the constants. It widens RGB565 values with random junk in the upper half, so a design that fails to ignore those bits, or that zero-fills instead of replicating, gives wrong low channel bits. Key hits are forced with destinations whose widened value matches the key, in both depths, and a design that compares before widening misses them. Random output stalls check that the held beat stays put, and streams with no stall check the three-cycle latency.

// File: rtl/rop3_pkg.sv
package rop3_pkg;
  localparam int unsigned PIX_W = 32;
  typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/rop3_expand.sv
module rop3_expand
  import rop3_pkg::*;
(
  input  logic is16_i,
  input  pix_t pix_i,
  output pix_t pix_o
);
  logic [4:0] r5, b5;
  logic [5:0] g6;
  assign r5 = pix_i[15:11];
  assign g6 = pix_i[10:5];
  assign b5 = pix_i[4:0];

  always_comb begin
    if (is16_i) pix_o = {8'hFF, r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
    else        pix_o = pix_i;
  end
endmodule

// File: rtl/rop3_logic.sv
module rop3_logic
  import rop3_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3,
  localparam int unsigned CODE_W = 2 ** NUM_SRC
) (
  input  logic [CODE_W-1:0]       code_i,
  input  pix_t [NUM_SRC-1:0]      src_i,
  output pix_t                    res_o
);
  for (genvar b = 0; b < PIX_W; b++) begin : g_bit
    logic [NUM_SRC-1:0] idx;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign idx[s] = src_i[s][b];
    end
    assign res_o[b] = code_i[idx];
  end
endmodule

// File: rtl/rop3_pack.sv
module rop3_pack
  import rop3_pkg::*;
(
  input  logic is16_i,
  input  pix_t pix_i,
  output pix_t pix_o
);
  always_comb begin
    if (is16_i) pix_o = {16'h0, pix_i[23:19], pix_i[15:10], pix_i[7:3]};
    else        pix_o = pix_i;
  end
endmodule

// File: rtl/rop3_pixel_unit.sv
module rop3_pixel_unit
  import rop3_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3,
  localparam int unsigned CODE_W = 2 ** NUM_SRC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [NUM_SRC*PIX_W-1:0] src_i,
  input  logic [PIX_W-1:0]         dst_i,
  input  logic [CODE_W-1:0]        rop_code_i,
  input  logic [NUM_SRC-1:0]       src_is16_i,
  input  logic                     dst_is16_i,
  input  logic                     key_en_i,
  input  logic [PIX_W-1:0]         key_color_i,
  input  logic [PIX_W-1:0]         plane_mask_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [PIX_W-1:0]         out_pix_o,
  output logic                     out_we_o
);
  logic adv;
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;

  // stage 1: widen
  pix_t [NUM_SRC-1:0] src_w, src_q;
  pix_t dst_w, dst_q1;
  logic v1;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_exp
    rop3_expand u_exp (
      .is16_i(src_is16_i[s]),
      .pix_i (src_i[s*PIX_W +: PIX_W]),
      .pix_o (src_w[s])
    );
  end

  rop3_expand u_exp_dst (.is16_i(dst_is16_i), .pix_i(dst_i), .pix_o(dst_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1     <= 1'b0;
      src_q  <= '0;
      dst_q1 <= '0;
    end else if (adv) begin
      v1 <= in_valid_i;
      if (in_valid_i) begin
        src_q  <= src_w;
        dst_q1 <= dst_w;
      end
    end
  end

  // stage 2: raster op and key compare
  pix_t rop_res, res_q, dst_q2;
  logic v2, hit_q;

  rop3_logic #(.NUM_SRC(NUM_SRC)) u_logic (
    .code_i(rop_code_i),
    .src_i (src_q),
    .res_o (rop_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2     <= 1'b0;
      res_q  <= '0;
      dst_q2 <= '0;
      hit_q  <= 1'b0;
    end else if (adv) begin
      v2 <= v1;
      if (v1) begin
        res_q  <= rop_res;
        dst_q2 <= dst_q1;
        hit_q  <= key_en_i && (dst_q1 == key_color_i);
      end
    end
  end

  // stage 3: mask, select, narrow
  pix_t merged, packed_pix;
  always_comb begin
    merged = (res_q & plane_mask_i) | (dst_q2 & ~plane_mask_i);
    if (hit_q) merged = dst_q2;
  end

  rop3_pack u_pack (.is16_i(dst_is16_i), .pix_i(merged), .pix_o(packed_pix));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pix_o   <= '0;
      out_we_o    <= 1'b0;
    end else if (adv) begin
      out_valid_o <= v2;
      if (v2) begin
        out_pix_o <= packed_pix;
        out_we_o  <= !hit_q;
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pix_o) && $stable(out_we_o));

  p_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  p_narrow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && dst_is16_i |-> out_pix_o[31:16] == 16'h0);

  p_keyout_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_we_o |-> key_en_i);
endmodule

// File: tb/rop3_pixel_unit_tb.sv
`timescale 1ns/1ps
module rop3_pixel_unit_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready, out_we;
  logic [95:0] src;
  logic [31:0] dst, key_color, plane_mask, out_pix;
  logic [7:0]  rop_code;
  logic [2:0]  src_is16;
  logic        dst_is16, key_en;

  rop3_pixel_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .src_i(src), .dst_i(dst), .rop_code_i(rop_code),
    .src_is16_i(src_is16), .dst_is16_i(dst_is16),
    .key_en_i(key_en), .key_color_i(key_color), .plane_mask_i(plane_mask),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_pix_o(out_pix), .out_we_o(out_we)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  bit nostall = 0;
  bit prev_stall = 0;
  logic [31:0] held_pix;
  logic held_we;
  logic [31:0] q_pix[$];
  logic        q_we[$];
  int          q_t[$];
  string       q_tag[$];

  always @(posedge clk) cyc++;

  function automatic logic [31:0] widen(input logic is16, input logic [31:0] p);
    logic [31:0] r;
    if (!is16) return p;
    r[31:24] = 8'hFF;
    r[23:16] = {p[15:11], p[15:13]};
    r[15:8]  = {p[10:5], p[10:9]};
    r[7:0]   = {p[4:0], p[4:2]};
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic model_push();
    logic [31:0] w[3];
    logic [31:0] d, r, m;
    bit hit;
    string tag;
    for (int s = 0; s < 3; s++) w[s] = widen(src_is16[s], src[s*32 +: 32]);
    d = widen(dst_is16, dst);
    for (int b = 0; b < 32; b++) begin
      int idx;
      idx = (w[2][b] ? 4 : 0) + (w[1][b] ? 2 : 0) + (w[0][b] ? 1 : 0);
      r[b] = rop_code[idx];
    end
    m = (r & plane_mask) | (d & ~plane_mask);
    hit = key_en && (d == key_color);
    if (hit) m = d;
    if (dst_is16) m = {16'h0, m[23:19], m[15:10], m[7:3]};
    if (hit) tag = "R5";
    else if (dst_is16) tag = "R6";
    else if (src_is16 != 3'b000 && src_is16 != 3'b111) tag = "R2";
    else if (src_is16 == 3'b111) tag = "R1";
    else if (plane_mask != 32'hFFFF_FFFF) tag = "R4";
    else tag = "R3";
    q_pix.push_back(m);
    q_we.push_back(!hit);
    q_t.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  // evaluate the cycle after inputs are set, then move to next negedge
  task automatic tick();
    #1;
    if (prev_stall && out_valid)
      check(out_pix == held_pix && out_we == held_we, "R8 hold", out_pix, held_pix);
    prev_stall = out_valid && !out_ready;
    held_pix = out_pix;
    held_we = out_we;
    if (out_valid && out_ready) begin
      if (q_pix.size() == 0) begin
        check(1'b0, "R8 extra beat", out_pix, 32'h0);
      end else begin
        logic [31:0] ep;
        logic ew;
        int t;
        string tg;
        ep = q_pix.pop_front(); ew = q_we.pop_front();
        t = q_t.pop_front(); tg = q_tag.pop_front();
        check(out_pix == ep, tg, out_pix, ep);
        check(out_we == ew, {tg, " we"}, {31'h0, out_we}, {31'h0, ew});
        if (nostall) check(cyc - t == 3, "R7 latency", cyc - t, 3);
      end
    end
    if (in_valid && in_ready) model_push();
    @(negedge clk);
  endtask

  task automatic drain();
    in_valid = 0;
    out_ready = 1;
    while (q_pix.size() != 0) tick();
    tick();
    tick();
  endtask

  task automatic rand_beat(input logic [15:0] key16, input int hitpct);
    src = {$urandom, $urandom, $urandom};
    dst = $urandom;
    if (key_en && ($urandom % 100) < hitpct)
      dst = dst_is16 ? {16'($urandom), key16} : key_color;
  endtask

  task automatic stream(input int n, input int stall_pct, input int gap_pct, input logic [15:0] key16);
    int sent = 0;
    while (sent < n) begin
      in_valid = (($urandom % 100) >= gap_pct);
      out_ready = (($urandom % 100) >= stall_pct);
      rand_beat(key16, 30);
      #1;
      if (in_valid && in_ready) sent++;
      #0;
      // tick re-samples after the same settle point
      tick_nosettle();
    end
    drain();
  endtask

  task automatic tick_nosettle();
    if (prev_stall && out_valid)
      check(out_pix == held_pix && out_we == held_we, "R8 hold", out_pix, held_pix);
    prev_stall = out_valid && !out_ready;
    held_pix = out_pix;
    held_we = out_we;
    if (out_valid && out_ready) begin
      if (q_pix.size() == 0) begin
        check(1'b0, "R8 extra beat", out_pix, 32'h0);
      end else begin
        logic [31:0] ep;
        logic ew;
        int t;
        string tg;
        ep = q_pix.pop_front(); ew = q_we.pop_front();
        t = q_t.pop_front(); tg = q_tag.pop_front();
        check(out_pix == ep, tg, out_pix, ep);
        check(out_we == ew, {tg, " we"}, {31'h0, out_we}, {31'h0, ew});
        if (nostall) check(cyc - t == 3, "R7 latency", cyc - t, 3);
      end
    end
    if (in_valid && in_ready) model_push();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes[7];
    rst_n = 0;
    in_valid = 0; out_ready = 1;
    src = '0; dst = '0; rop_code = 8'hAA;
    src_is16 = 3'b000; dst_is16 = 0; key_en = 0;
    key_color = '0; plane_mask = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 valid in reset", {31'h0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R9 ready in reset", {31'h0, in_ready}, 32'h1);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 valid after reset", {31'h0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R9 ready after reset", {31'h0, in_ready}, 32'h1);

    // R3 directed codes, single beats, no stall (R7 latency)
    codes = '{8'hAA, 8'hCC, 8'hF0, 8'h96, 8'h80, 8'h00, 8'hFF};
    nostall = 1;
    foreach (codes[i]) begin
      rop_code = codes[i];
      src = {32'hFF00_FF00, 32'hF0F0_F0F0, 32'hCCCC_CCCC};
      dst = 32'h1234_5678;
      in_valid = 1; out_ready = 1;
      tick();
      in_valid = 0;
      drain();
    end

    // R1: constant RGB565 source with junk upper half, copied through code AA
    src_is16 = 3'b111;
    rop_code = 8'hAA;
    src = {32'h0, 32'h0, 32'hDEAD_8A53};
    in_valid = 1;
    tick();
    in_valid = 0;
    drain();

    for (int k = 0; k < 14; k++) begin
      logic [15:0] key16;
      rop_code = 8'($urandom);
      src_is16 = 3'($urandom);
      dst_is16 = $urandom % 2;
      plane_mask = $urandom;
      key_en = $urandom % 2;
      key16 = 16'($urandom);
      key_color = $urandom;
      case (k)
        0: begin src_is16 = 3'b000; dst_is16 = 0; plane_mask = '1; key_en = 0; end
        1: begin src_is16 = 3'b111; dst_is16 = 0; plane_mask = '1; key_en = 0; end
        2: begin src_is16 = 3'b101; dst_is16 = 0; plane_mask = '1; key_en = 0; end
        3: begin src_is16 = 3'b000; dst_is16 = 0; key_en = 0; end
        4: begin dst_is16 = 0; key_en = 1; end
        5: begin dst_is16 = 1; key_en = 1; end
        6: begin dst_is16 = 1; key_en = 0; end
        default: ;
      endcase
      if (key_en && dst_is16) key_color = widen(1'b1, {16'h0, key16});
      nostall = (k % 2 == 0);
      stream(300, nostall ? 0 : 35, 20, key16);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule